// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block turns a device-side I/O address into a real memory address by walking two tables. The upper address bits, taken above bit 28, pick an entry in a segment table. That entry says whether the segment is mapped, which page size it uses, where its page table starts, and how many 4 KB pages the page table spans. The lower 28 bits, shifted right by the segment's page shift, give a page number. That page number picks a page entry, which supplies the real page number, the read and write permissions, an ordering code, a coherence flag and an 11-bit device identifier.

Both tables sit in internal RAMs written through a simple table-load port. Two configuration registers gate the whole function. One is a segment-origin register with an enable bit. The other is a command configuration register with a translation-enable bit. Unless both bits are set, addresses flow through unchanged. Requests enter through a valid/ready handshake. Each result leaves two cycles later through a second valid/ready handshake, with any segment fault or page fault flagged beside it.

Top module: `io_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and translation is off.
- R2: A request accepted at a rising edge (req_valid and req_ready both high) appears on the response port after the second following rising edge. While rsp_valid is high and rsp_ready is low, req_ready is low and every response output holds its value.
- R3: Unless the origin enable and the translation enable are both set, rsp_addr equals req_addr zero-extended. In that case both fault flags are 0 and rsp_ioid, rsp_order and rsp_coh are 0.
- R4: The segment entry is taken from the segment RAM at index req_addr >> 28. If bit 63 of that entry (valid) is 0, the response carries rsp_seg_fault = 1.
- R5: The page-size code in segment-entry bits 2:0 maps as follows: 1 selects a 12-bit page shift, 3 selects 16, 5 selects 20 and 7 selects 24. Any other code gives rsp_seg_fault = 1.
- R6: The page number is req_addr[27:shift]. The page RAM index is the low log2(PT_DEPTH) bits of (segment-entry bits 61:12) × 512 + page number. If the page number is not below (segment-entry bits 11:5 + 1) × 512, the response carries rsp_page_fault = 1.
- R7: A read needs page-entry bit 62 set, and a write needs page-entry bit 63 set. If the needed bit is clear, the response carries rsp_page_fault = 1.
- R8: On a successful translation, rsp_addr is page-entry bits 51:12 shifted left by 12. Its low `shift` bits are then replaced by the same bits of req_addr.
- R9: On a successful translation, rsp_ioid is page-entry bits 10:0, rsp_order is bits 60:59 and rsp_coh is bit 61. On any fault, rsp_addr and all three attribute outputs are 0. A segment fault suppresses the page fault.
- R10: A write with cfg_sel = 0 loads the origin enable from cfg_wdata bit 63. A write with cfg_sel = 1 loads the translation enable from cfg_wdata bit 47. Writing the origin register as 0 turns translation off for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 = segment origin register, 1 = command configuration register |
| cfg_wdata | input | 64 | Configuration write data |
| tbl_wr | input | 1 | Table RAM write strobe |
| tbl_sel | input | 1 | 0 = segment RAM, 1 = page RAM |
| tbl_addr | input | TBL_AW | Table RAM entry index |
| tbl_wdata | input | 64 | Table entry data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | IOA_W | Device I/O address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 52 | Real address, or pass-through address |
| rsp_ioid | output | 11 | Device identifier from the page entry |
| rsp_order | output | 2 | Ordering code from the page entry |
| rsp_coh | output | 1 | Coherence flag from the page entry |
| rsp_seg_fault | output | 1 | Segment entry invalid or page-size code unknown |
| rsp_page_fault | output | 1 | Page number out of table range, or access not permitted |

## Verification
Two situations are hard to reach with random stimulus, so the address generator is steered toward both. The first is a page number that sits just at or past the end of a segment's page table. With 4 KB pages a uniform address almost never lands there. The generator therefore reads the segment entry it has picked and draws the page number from a window that straddles the table limit. The second is a response held under backpressure while new requests wait behind it. The streaming phase throttles rsp_ready at random, checks that a stalled response does not change, and scores every result in order against a model built from the table images the bench itself loaded.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;

    localparam int SEG_SHIFT     = 28;
    localparam int PT_PAGE_BITS  = 9;   // 512 eight-byte entries per 4 KB table page
    localparam int RA_W          = 52;
    localparam int ID_W          = 11;

    // segment entry layout
    typedef struct packed {
        logic        valid;      // 63
        logic        hint;       // 62
        logic [49:0] pt_rpn;     // 61:12
        logic [6:0]  npg_m1;     // 11:5
        logic [1:0]  rsvd;       // 4:3
        logic [2:0]  psize;      // 2:0
    } seg_ent_t;

    // page entry layout
    typedef struct packed {
        logic            can_wr; // 63
        logic            can_rd; // 62
        logic            coh;    // 61
        logic [1:0]      order;  // 60:59
        logic [6:0]      rsvd_h; // 58:52
        logic [39:0]     rpn;    // 51:12
        logic            rsvd_l; // 11
        logic [ID_W-1:0] ioid;   // 10:0
    } pg_ent_t;

    // state carried from the segment stage to the page stage
    typedef struct packed {
        logic [63:0] ioa;
        logic        write;
        logic        xlate;
        logic        seg_fault;
        logic [4:0]  shift;
        logic [49:0] pt_rpn;
        logic [6:0]  npg_m1;
    } seg_stage_t;

    // one response word
    typedef struct packed {
        logic [RA_W-1:0] ra;
        logic [ID_W-1:0] ioid;
        logic [1:0]      order;
        logic            coh;
        logic            seg_fault;
        logic            page_fault;
    } xl_rsp_t;

    // page-size code to page shift; 0 marks an unknown code
    function automatic logic [4:0] size_to_shift(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd12;
            3'd3:    return 5'd16;
            3'd5:    return 5'd20;
            3'd7:    return 5'd24;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/io_xlate_ram.sv
module io_xlate_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [63:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [63:0]   rdata
);
    logic [63:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/io_xlate_ctl.sv
module io_xlate_ctl (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [63:0] cfg_wdata,
    output logic        xlate_en
);
    logic origin_en;
    logic cmd_te;

    always_ff @(posedge clk) begin
        if (rst) begin
            origin_en <= 1'b0;
            cmd_te    <= 1'b0;
        end else if (cfg_wr) begin
            if (!cfg_sel) origin_en <= cfg_wdata[63];
            else          cmd_te    <= cfg_wdata[47];
        end
    end

    assign xlate_en = origin_en && cmd_te;

    // R10: clearing the origin register turns translation off
    a_r10_origin_clear_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel && cfg_wdata == 64'd0) |=> !xlate_en);
endmodule

// File: rtl/io_xlate_seg_stage.sv
module io_xlate_seg_stage
    import io_xlate_pkg::*;
#(
    parameter int IOA_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             req_valid,
    input  logic [IOA_W-1:0] req_addr,
    input  logic             req_write,
    input  logic             xlate_en,
    input  logic [63:0]      seg_word,
    output logic             a_valid,
    output seg_stage_t       a_q
);
    seg_ent_t   ste;
    seg_stage_t nxt;

    assign ste = seg_ent_t'(seg_word);

    always_comb begin
        nxt           = '0;
        nxt.ioa       = 64'(req_addr);
        nxt.write     = req_write;
        nxt.xlate     = xlate_en;
        nxt.shift     = size_to_shift(ste.psize);
        nxt.pt_rpn    = ste.pt_rpn;
        nxt.npg_m1    = ste.npg_m1;
        nxt.seg_fault = xlate_en && (!ste.valid || nxt.shift == 5'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_q     <= '0;
        end else if (advance) begin
            a_valid <= req_valid;
            a_q     <= nxt;
        end
    end

    // R4: an invalid segment entry seen on acceptance becomes a segment fault
    a_r4_invalid_segment: assert property (@(posedge clk) disable iff (rst)
        (advance && req_valid && xlate_en && !seg_word[63]) |=> (a_valid && a_q.seg_fault));

    // R3: nothing faults in the segment stage while translation is off
    a_r3_bypass_no_fault: assert property (@(posedge clk) disable iff (rst)
        (advance && req_valid && !xlate_en) |=> (a_valid && !a_q.seg_fault));
endmodule

// File: rtl/io_xlate_page_stage.sv
module io_xlate_page_stage
    import io_xlate_pkg::*;
#(
    parameter int PT_AW = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             a_valid,
    input  seg_stage_t       a_q,
    output logic [PT_AW-1:0] pt_idx,
    input  logic [63:0]      pg_word,
    output logic             b_valid,
    output xl_rsp_t          b_q
);
    pg_ent_t     pte;
    logic [27:0] page_no;
    logic [16:0] limit;
    logic        in_range;
    logic        perm_ok;
    logic [63:0] idx_sum;
    logic [63:0] mask;
    logic [63:0] full_ra;
    xl_rsp_t     nxt;

    assign pte      = pg_ent_t'(pg_word);
    assign page_no  = a_q.ioa[SEG_SHIFT-1:0] >> a_q.shift;
    assign limit    = {({1'b0, a_q.npg_m1} + 8'd1), {PT_PAGE_BITS{1'b0}}};
    assign in_range = page_no < 28'(limit);
    assign idx_sum  = 64'({a_q.pt_rpn, {PT_PAGE_BITS{1'b0}}}) + 64'(page_no);
    assign pt_idx   = idx_sum[PT_AW-1:0];
    assign perm_ok  = a_q.write ? pte.can_wr : pte.can_rd;
    assign mask     = (64'd1 << a_q.shift) - 64'd1;
    assign full_ra  = ({12'd0, pte.rpn, 12'd0} & ~mask) | (a_q.ioa & mask);

    always_comb begin
        nxt = '0;
        if (!a_q.xlate) begin
            nxt.ra = a_q.ioa[RA_W-1:0];
        end else if (a_q.seg_fault) begin
            nxt.seg_fault = 1'b1;
        end else if (!in_range || !perm_ok) begin
            nxt.page_fault = 1'b1;
        end else begin
            nxt.ra    = full_ra[RA_W-1:0];
            nxt.ioid  = pte.ioid;
            nxt.order = pte.order;
            nxt.coh   = pte.coh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_valid <= 1'b0;
            b_q     <= '0;
        end else if (advance) begin
            b_valid <= a_valid;
            b_q     <= nxt;
        end
    end

    // R7: a page entry lacking the needed permission yields a page fault
    a_r7_no_permission: assert property (@(posedge clk) disable iff (rst)
        (advance && a_valid && a_q.xlate && !a_q.seg_fault &&
         !(a_q.write ? pg_word[63] : pg_word[62])) |=> (b_valid && b_q.page_fault));

    // R9: a segment fault is never reported together with a page fault
    a_r9_seg_over_page: assert property (@(posedge clk) disable iff (rst)
        (advance && a_valid && a_q.seg_fault) |=> (b_q.seg_fault && !b_q.page_fault));
endmodule

// File: rtl/io_xlate.sv
module io_xlate
    import io_xlate_pkg::*;
#(
    parameter  int IOA_W    = 32,
    parameter  int PT_DEPTH = 1024,
    localparam int SEG_AW   = IOA_W - SEG_SHIFT,
    localparam int SEG_N    = 1 << SEG_AW,
    localparam int PT_AW    = $clog2(PT_DEPTH),
    localparam int TBL_AW   = (PT_AW > SEG_AW) ? PT_AW : SEG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [63:0]       cfg_wdata,
    input  logic              tbl_wr,
    input  logic              tbl_sel,
    input  logic [TBL_AW-1:0] tbl_addr,
    input  logic [63:0]       tbl_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOA_W-1:0]  req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [RA_W-1:0]   rsp_addr,
    output logic [ID_W-1:0]   rsp_ioid,
    output logic [1:0]        rsp_order,
    output logic              rsp_coh,
    output logic              rsp_seg_fault,
    output logic              rsp_page_fault
);
    logic             xlate_en;
    logic             advance;
    logic [63:0]      seg_word;
    logic [63:0]      pg_word;
    logic [PT_AW-1:0] pt_idx;
    logic             a_valid;
    seg_stage_t       a_q;
    logic             b_valid;
    xl_rsp_t          b_q;

    assign advance   = !b_valid || rsp_ready;
    assign req_ready = advance;

    io_xlate_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .xlate_en  (xlate_en)
    );

    io_xlate_ram #(.DEPTH(SEG_N), .AW(SEG_AW)) u_seg_ram (
        .clk   (clk),
        .we    (tbl_wr && !tbl_sel),
        .waddr (tbl_addr[SEG_AW-1:0]),
        .wdata (tbl_wdata),
        .raddr (req_addr[IOA_W-1:SEG_SHIFT]),
        .rdata (seg_word)
    );

    io_xlate_ram #(.DEPTH(PT_DEPTH), .AW(PT_AW)) u_pg_ram (
        .clk   (clk),
        .we    (tbl_wr && tbl_sel),
        .waddr (tbl_addr[PT_AW-1:0]),
        .wdata (tbl_wdata),
        .raddr (pt_idx),
        .rdata (pg_word)
    );

    io_xlate_seg_stage #(.IOA_W(IOA_W)) u_seg (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .xlate_en  (xlate_en),
        .seg_word  (seg_word),
        .a_valid   (a_valid),
        .a_q       (a_q)
    );

    io_xlate_page_stage #(.PT_AW(PT_AW)) u_page (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .a_valid (a_valid),
        .a_q     (a_q),
        .pt_idx  (pt_idx),
        .pg_word (pg_word),
        .b_valid (b_valid),
        .b_q     (b_q)
    );

    assign rsp_valid      = b_valid;
    assign rsp_addr       = b_q.ra;
    assign rsp_ioid       = b_q.ioid;
    assign rsp_order      = b_q.order;
    assign rsp_coh        = b_q.coh;
    assign rsp_seg_fault  = b_q.seg_fault;
    assign rsp_page_fault = b_q.page_fault;

    // R2: an accepted request occupies the first stage one edge later
    a_r2_accept_to_stage: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> a_valid);

    // R2: a stalled response holds still
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
            $stable(rsp_ioid) && $stable(rsp_seg_fault) && $stable(rsp_page_fault)));

    // R9: faulting responses carry no address or attributes
    a_r9_fault_clears: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_seg_fault || rsp_page_fault)) |->
            (rsp_addr == '0 && rsp_ioid == '0 && rsp_order == 2'd0 && !rsp_coh));
endmodule

// File: tb/test_io_xlate.sv
`timescale 1ns/1ps
module test_io_xlate;
    typedef struct packed {
        logic [51:0] ra;
        logic [10:0] ioid;
        logic [1:0]  order;
        logic        coh;
        logic        sf;
        logic        pf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        tbl_wr = 1'b0, tbl_sel = 1'b0;
    logic [9:0]  tbl_addr = '0;
    logic [63:0] tbl_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [51:0] rsp_addr;
    logic [10:0] rsp_ioid;
    logic [1:0]  rsp_order;
    logic        rsp_coh, rsp_seg_fault, rsp_page_fault;

    int checks = 0;
    int errors = 0;

    logic [63:0] seg_m [16];
    logic [63:0] pt_m  [1024];
    logic        m_org = 1'b0, m_te = 1'b0;

    always #2.5 clk = ~clk;

    io_xlate i_io_xlate (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .tbl_wr(tbl_wr), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_ioid(rsp_ioid),
        .rsp_order(rsp_order), .rsp_coh(rsp_coh), .rsp_seg_fault(rsp_seg_fault),
        .rsp_page_fault(rsp_page_fault)
    );

    function automatic int shift_of(input logic [2:0] c);
        case (c)
            3'd1: return 12;
            3'd3: return 16;
            3'd5: return 20;
            3'd7: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic w);
        exp_t e;
        logic [63:0] ste, pte, mask, ra;
        longint unsigned pn, lim, idx;
        int sh;
        e = '0;
        if (!(m_org && m_te)) begin e.ra = 52'(a); return e; end
        ste = seg_m[a[31:28]];
        sh  = shift_of(ste[2:0]);
        if (!ste[63] || sh == 0) begin e.sf = 1'b1; return e; end
        pn  = longint'(a[27:0]) >> sh;
        lim = (longint'(ste[11:5]) + 1) * 512;
        if (pn >= lim) begin e.pf = 1'b1; return e; end
        idx = ((longint'(ste[61:12]) * 512) + pn) % 1024;
        pte = pt_m[idx];
        if (!(w ? pte[63] : pte[62])) begin e.pf = 1'b1; return e; end
        mask    = (64'd1 << sh) - 64'd1;
        ra      = ({12'd0, pte[51:12], 12'd0} & ~mask) | (64'(a) & mask);
        e.ra    = ra[51:0];
        e.ioid  = pte[10:0];
        e.order = pte[60:59];
        e.coh   = pte[61];
        return e;
    endfunction

    function automatic exp_t actual();
        exp_t x;
        x.ra = rsp_addr; x.ioid = rsp_ioid; x.order = rsp_order;
        x.coh = rsp_coh; x.sf = rsp_seg_fault; x.pf = rsp_page_fault;
        return x;
    endfunction

    task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic sel, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (!sel) m_org = d[63]; else m_te = d[47];
    endtask

    task automatic wr_tbl(input logic sel, input int idx, input logic [63:0] d);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_sel = sel; tbl_addr = 10'(idx); tbl_wdata = d;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (!sel) seg_m[idx] = d; else pt_m[idx] = d;
    endtask

    // one isolated request, result sampled after the second edge
    task automatic one_req(input string req, input logic [31:0] a, input logic w);
        exp_t e;
        e = model(a, w);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R2 not early"}, 68'(rsp_valid), 68'(0));
        @(negedge clk);
        chk({req, " R2 valid"}, 68'(rsp_valid), 68'(1));
        chk(req, actual(), e);
    endtask

    function automatic logic [31:0] gen_addr();
        int s, sh;
        longint unsigned lim, pn, maxpn;
        logic [63:0] ste;
        s   = $urandom % 16;
        ste = seg_m[s];
        sh  = shift_of(ste[2:0]);
        if (sh == 0) sh = 12;
        lim   = (longint'(ste[11:5]) + 1) * 512;
        maxpn = (longint'(1) << (28 - sh)) - 1;
        pn = (lim > 8) ? (lim - 8 + ($urandom % 12)) : ($urandom % 12);
        if ($urandom % 2) pn = $urandom % (lim + 1);
        if (pn > maxpn) pn = $urandom % (maxpn + 1);
        return {4'(s), 28'((pn << sh) | ($urandom & ((1 << sh) - 1)))};
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        exp_t q[$];
        logic [51:0] held;
        logic        stalled;
        bit          need_new;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 68'(rsp_valid), 68'(0));
        chk("R1 req_ready after reset", 68'(req_ready), 68'(1));

        // load segment images
        for (int s = 0; s < 16; s++) begin
            logic [63:0] d;
            logic [2:0]  codes [4];
            codes = '{3'd1, 3'd3, 3'd5, 3'd7};
            d = '0;
            d[63] = (s != 0);
            d[62] = $urandom % 2;
            d[61:12] = (s == 15) ? 50'd3 : 50'($urandom % 2);
            d[11:5]  = 7'($urandom % 4);
            d[2:0]   = (s == 1) ? 3'd2 : codes[s % 4];
            wr_tbl(1'b0, s, d);
        end
        for (int i = 0; i < 1024; i++) wr_tbl(1'b1, i, {$urandom, $urandom});

        // R1 R3: translation off after reset, pass-through
        one_req("R1 R3 bypass after reset", 32'hA123_4567, 1'b0);
        chk("R3 bypass literal", 68'(rsp_addr), 68'(52'hA123_4567));

        // R10: origin alone is not enough
        wr_cfg(1'b0, 64'h8000_0000_0000_0000);
        one_req("R10 R3 only origin set", 32'h2000_5ABC, 1'b0);

        wr_cfg(1'b1, 64'h0000_8000_0000_0000);

        // directed table contents
        wr_tbl(1'b0, 2, {1'b1, 1'b0, 50'd0, 7'd0, 2'd0, 3'd1});
        wr_tbl(1'b1, 5, {1'b1, 1'b1, 1'b1, 2'b10, 7'd0, 40'h12345, 1'b0, 11'h2AB});
        wr_tbl(1'b1, 6, {1'b0, 1'b1, 1'b0, 2'b01, 7'd0, 40'h00777, 1'b0, 11'h011});
        wr_tbl(1'b0, 3, {1'b1, 1'b0, 50'd1, 7'd0, 2'd0, 3'd7});
        wr_tbl(1'b1, 527, {1'b0, 1'b1, 1'b0, 2'b11, 7'd0, 40'hABCDE, 1'b0, 11'h7FF});

        one_req("R8 R9 4K hit", 32'h2000_5ABC, 1'b0);
        chk("R8 4K literal addr", 68'(rsp_addr), 68'(52'h1234_5ABC));
        chk("R9 literal attrs", 68'({rsp_ioid, rsp_order, rsp_coh}), 68'({11'h2AB, 2'b10, 1'b1}));
        one_req("R7 write without permission", 32'h2000_6000, 1'b1);
        chk("R7 literal page fault", 68'(rsp_page_fault), 68'(1));
        one_req("R7 read permitted", 32'h2000_6004, 1'b0);
        one_req("R6 page beyond table", 32'h2020_0000, 1'b0);
        chk("R6 literal page fault", 68'(rsp_page_fault), 68'(1));
        one_req("R8 16M hit", 32'h3F12_3456, 1'b0);
        chk("R8 16M literal addr", 68'(rsp_addr), 68'(52'hAB12_3456));
        one_req("R4 invalid segment", 32'h0000_1000, 1'b0);
        chk("R4 literal seg fault", 68'({rsp_seg_fault, rsp_page_fault}), 68'(2'b10));
        one_req("R5 unknown size code", 32'h1000_0000, 1'b1);
        chk("R5 literal seg fault", 68'(rsp_seg_fault), 68'(1));
        one_req("R6 index wrap", 32'hF000_0000 | 32'(($urandom % 4) << 12), 1'b0);

        // streaming with random backpressure
        need_new = 1'b1;
        stalled  = 1'b0;
        held     = '0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (stalled) begin
                chk("R2 stall hold", 68'({rsp_valid, rsp_addr}), 68'({1'b1, held}));
            end
            rsp_ready = ($urandom % 4) != 0;
            if (need_new) begin
                req_valid = (cyc < 2900) && (($urandom % 5) != 0);
                req_addr  = gen_addr();
                req_write = $urandom % 2;
            end
            #1;
            stalled = rsp_valid && !rsp_ready;
            held    = rsp_addr;
            if (rsp_valid && rsp_ready) begin
                if (q.size() == 0) chk("R2 unexpected response", 68'(1), 68'(0));
                else chk("R4 R5 R6 R7 R8 R9 stream", actual(), q.pop_front());
            end
            if (req_valid && req_ready) begin
                q.push_back(model(req_addr, req_write));
                need_new = 1'b1;
            end else begin
                need_new = !req_valid;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 all responses drained", 68'(q.size()), 68'(0));

        // R10: clearing origin returns to pass-through
        wr_cfg(1'b0, 64'd0);
        one_req("R10 origin cleared", 32'h2000_5ABC, 1'b0);
        chk("R10 literal bypass", 68'(rsp_addr), 68'(52'h2000_5ABC));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule